// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block brings one cache line in from a memory port that is narrower than the line, one beat per response. A requester hands it a byte address of any alignment. The engine drops the in-line offset to get the line base. It then asks memory first for the beat that holds the addressed byte. After that it walks forward through the other beats, wrapping from the last beat of the line back to beat zero, until every beat has been requested.

Memory answers in the order it was asked and carries no address with its data. The engine therefore places each arriving beat by its position in the wrap order. It writes the beat into an internal line buffer and sets that beat's bit in a valid mask. When the first beat (the critical one) lands, the engine raises a one-cycle early-ready pulse and shows the critical data on a dedicated output, so the consumer can restart before the fill is complete. A one-cycle done pulse marks the arrival of the last beat. The buffer can be read one beat at a time through a registered read port.

Only one fill runs at a time. A request for the line already in flight is merged into that fill. A request for any other line waits until the engine is idle.

Top module: `cwf_line_fill`

## Requirements
- R1: On acceptance, `line_addr` becomes the request address with its low log2(LINE_BYTES) bits (6 by default) cleared, and every memory request of that fill lies inside that line and is beat-aligned.
- R2: The first memory request of a fill is for the beat that holds the addressed byte: line base + addr[5:3]*8 with the default 64-byte line and 64-bit beat.
- R3: Each further request moves to the next beat index modulo BEATS. A fill issues exactly BEATS requests, 8 by default.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.
- R5: The k-th response of a fill (k counted from 0) is stored in beat (start + k) mod BEATS, and sets that beat's bit of `beat_valid`. No bit clears until a new fill is accepted.
- R6: One cycle after the first response, `crit_ready` pulses for one cycle. At that moment `crit_data` equals the critical beat's data, and `beat_valid` has only the critical beat's bit set.
- R7: One cycle after the last response, `fill_done` pulses for one cycle. At that moment `beat_valid` is all ones and `req_ready` is high.
- R8: When idle, `req_ready` is high. Accepting a request clears `beat_valid` to zero.
- R9: During a fill, a request for a different line sees `req_ready` low and is not accepted. It causes no extra memory request and leaves `line_addr` unchanged.
- R10: During a fill, a request whose line matches the active line sees `req_ready` high and is merged. No new fill starts and no extra memory request is issued.
- R11: `rd_data` shows the buffer beat selected by `rd_idx` one cycle later. The contents stay after `fill_done`.
- R12: After reset, `req_ready` is high, and `mem_req_valid`, `beat_valid`, `crit_ready` and `fill_done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request present |
| req_addr | input | ADDR_W | Byte address, any alignment |
| req_ready | output | 1 | Request is accepted or merged this cycle |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | ADDR_W | Beat-aligned read address |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Response beat present, in request order |
| mem_rsp_data | input | BEAT_BITS | Response beat data |
| line_addr | output | ADDR_W | Line base of the current or last fill |
| beat_valid | output | BEATS | Per-beat valid mask |
| crit_ready | output | 1 | Critical beat arrived (one-cycle pulse) |
| crit_data | output | BEAT_BITS | Critical beat data |
| fill_done | output | 1 | Whole line present (one-cycle pulse) |
| rd_idx | input | IDX_W | Line buffer beat to read |
| rd_data | output | BEAT_BITS | Registered read data |

## Verification
Fills are started at three kinds of offset: offset zero, where the wrap order is a plain ascending walk; the last byte of the line, where the order wraps right after the first beat; and random offsets, which cover starting points in the middle of the line. Memory stalls requests and delays responses at random. This separates placement by response order from placement by arrival timing, and shows whether the request address holds during a stall. Some fills get a second request during the fill, either for the same line or for a different one. Counting memory requests and checking `line_addr` tells a merge apart from a blocked request and from a wrong restart.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    FILL_IDLE   = 1'b0,
    FILL_ACTIVE = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cwf_wrap_idx.sv
// Beat index inside a line: start plus step, wrapping by truncation
// (BEATS is a power of two).
module cwf_wrap_idx #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] start,
  input  logic [IDX_W-1:0] step,
  output logic [IDX_W-1:0] idx
);
  assign idx = start + step;
endmodule

// File: rtl/cwf_line_buf.sv
// One line of storage: single write port, registered read port.
module cwf_line_buf #(
  parameter int BEATS  = 8,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [BEATS];

  always_ff @(posedge clk) begin
    if (we) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= store[rd_idx];
  end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 64,
  parameter  int BEAT_BITS  = 64,
  localparam int BEAT_BYTES = BEAT_BITS / 8,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int IDX_W      = $clog2(BEATS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 req_ready,
  output logic                 mem_req_valid,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic [BEAT_BITS-1:0] mem_rsp_data,
  output logic [ADDR_W-1:0]    line_addr,
  output logic [BEATS-1:0]     beat_valid,
  output logic                 crit_ready,
  output logic [BEAT_BITS-1:0] crit_data,
  output logic                 fill_done,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [BEAT_BITS-1:0] rd_data
);
  import cwf_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(BEAT_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  fill_state_e      state_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] iss_cnt_q;
  logic [IDX_W-1:0] rsp_cnt_q;
  logic [IDX_W-1:0] req_idx_q;
  logic [IDX_W-1:0] iss_next;
  logic [IDX_W-1:0] wr_idx;
  logic             req_hit;
  logic             accept;
  logic             rsp_take;

  // Same-line requests during a fill are merged, others wait for idle.
  assign req_hit   = (state_q == FILL_ACTIVE) && (req_addr[ADDR_W-1:OFF_W] == tag_q);
  assign req_ready = (state_q == FILL_IDLE) || req_hit;
  assign accept    = req_valid && (state_q == FILL_IDLE);
  assign rsp_take  = (state_q == FILL_ACTIVE) && mem_rsp_valid;

  // Next request index in wrap order, and slot of the arriving beat.
  cwf_wrap_idx #(.IDX_W(IDX_W)) u_iss_wrap (
    .start (start_q),
    .step  (iss_cnt_q + 1'b1),
    .idx   (iss_next)
  );

  cwf_wrap_idx #(.IDX_W(IDX_W)) u_rsp_wrap (
    .start (start_q),
    .step  (rsp_cnt_q),
    .idx   (wr_idx)
  );

  cwf_line_buf #(.BEATS(BEATS), .DATA_W(BEAT_BITS), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .we      (rsp_take),
    .wr_idx  (wr_idx),
    .wr_data (mem_rsp_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  assign line_addr    = {tag_q, {OFF_W{1'b0}}};
  assign mem_req_addr = {tag_q, req_idx_q, {BOFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= FILL_IDLE;
      tag_q         <= '0;
      start_q       <= '0;
      iss_cnt_q     <= '0;
      rsp_cnt_q     <= '0;
      req_idx_q     <= '0;
      mem_req_valid <= 1'b0;
      beat_valid    <= '0;
      crit_ready    <= 1'b0;
      crit_data     <= '0;
      fill_done     <= 1'b0;
    end else begin
      crit_ready <= 1'b0;
      fill_done  <= 1'b0;
      if (accept) begin
        state_q       <= FILL_ACTIVE;
        tag_q         <= req_addr[ADDR_W-1:OFF_W];
        start_q       <= req_addr[OFF_W-1:BOFF_W];
        req_idx_q     <= req_addr[OFF_W-1:BOFF_W];
        iss_cnt_q     <= '0;
        rsp_cnt_q     <= '0;
        mem_req_valid <= 1'b1;
        beat_valid    <= '0;
      end else if (state_q == FILL_ACTIVE) begin
        if (mem_req_valid && mem_req_ready) begin
          if (iss_cnt_q == LAST_IDX) begin
            mem_req_valid <= 1'b0;
          end else begin
            iss_cnt_q <= iss_cnt_q + 1'b1;
            req_idx_q <= iss_next;
          end
        end
        if (rsp_take) begin
          beat_valid[wr_idx] <= 1'b1;
          rsp_cnt_q          <= rsp_cnt_q + 1'b1;
          if (rsp_cnt_q == '0) begin
            crit_ready <= 1'b1;
            crit_data  <= mem_rsp_data;
          end
          if (rsp_cnt_q == LAST_IDX) begin
            fill_done <= 1'b1;
            state_q   <= FILL_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 64,
  parameter  int BEAT_BITS  = 64,
  localparam int BEAT_BYTES = BEAT_BITS / 8,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int BOFF_W     = $clog2(BEAT_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] line_addr,
  input logic [BEATS-1:0]  beat_valid,
  input logic              crit_ready,
  input logic              fill_done
);
  assert_req_in_line_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[ADDR_W-1:OFF_W] == line_addr[ADDR_W-1:OFF_W])
                      && (mem_req_addr[BOFF_W-1:0] == '0));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_mask_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> ((beat_valid & $past(beat_valid)) == $past(beat_valid)));

  assert_crit_alone_R6: assert property (@(posedge clk) disable iff (rst)
    crit_ready |-> ($countones(beat_valid) == 1));

  assert_done_full_R7: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> ((&beat_valid) && req_ready));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);
endmodule

bind cwf_line_fill cwf_line_fill_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BEAT_BITS(BEAT_BITS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .line_addr(line_addr),
  .beat_valid(beat_valid), .crit_ready(crit_ready), .fill_done(fill_done)
);

// File: tb/test_cwf_line_fill.sv
`timescale 1ns/1ps
module test_cwf_line_fill;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [AW-1:0] line_addr;
  logic [7:0]    beat_valid;
  logic          crit_ready;
  logic [DW-1:0] crit_data;
  logic          fill_done;
  logic [2:0]    rd_idx = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cwf_line_fill i_cwf_line_fill (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .line_addr(line_addr), .beat_valid(beat_valid),
    .crit_ready(crit_ready), .crit_data(crit_data), .fill_done(fill_done),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_1234, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: stalls and delays at random, answers in order.
  logic [AW-1:0] q[$];
  logic [AW-1:0] exp_base = '0;
  logic [2:0]    exp_start = '0;
  int            nreq = 0;
  bit            stall_prev = 0;
  logic [AW-1:0] stall_addr = '0;

  always @(negedge clk) begin
    if (mem_rsp_valid) void'(q.pop_front());
    if (stall_prev) begin
      chk(mem_req_valid && mem_req_addr == stall_addr, "R4", mem_req_addr, stall_addr);
    end
    if (q.size() > 0 && ($urandom % 3 != 0)) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(q[0]);
    end else begin
      mem_rsp_valid = 1'b0;
    end
    mem_req_ready = ($urandom % 4 != 0);
    stall_prev = mem_req_valid && !mem_req_ready;
    stall_addr = mem_req_addr;
    if (mem_req_valid && mem_req_ready && !rst) begin
      logic [AW-1:0] e;
      logic [2:0]    bi;
      bi = exp_start + 3'(nreq);
      e  = exp_base + {26'd0, bi, 3'd0};
      chk(nreq < 8 && mem_req_addr == e, (nreq == 0) ? "R2" : "R3", mem_req_addr, e);
      q.push_back(mem_req_addr);
      nreq++;
    end
  end

  // mode 0: plain, 1: same-line request during fill, 2: other-line request
  task automatic do_fill(input logic [AW-1:0] a, input int mode);
    int  cyc = 0;
    bit  seen_crit = 0;
    bit  done = 0;
    logic [7:0] onehot;
    @(negedge clk);
    exp_base  = a & ~32'h3F;
    exp_start = a[5:3];
    nreq      = 0;
    req_valid = 1'b1;
    req_addr  = a;
    #1 chk(req_ready == 1'b1, "R8", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(line_addr == exp_base, "R1", line_addr, exp_base);
    chk(beat_valid == 8'd0, "R8", beat_valid, 64'd0);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (crit_ready) begin
        onehot = 8'd1 << exp_start;
        chk(!seen_crit && crit_data == mem_word(exp_base + {26'd0, exp_start, 3'd0}), "R6",
            crit_data, mem_word(exp_base + {26'd0, exp_start, 3'd0}));
        chk(beat_valid == onehot, "R6", beat_valid, onehot);
        seen_crit = 1;
      end
      if (fill_done) begin
        chk(beat_valid == 8'hFF && seen_crit, "R7", beat_valid, 64'hFF);
        chk(req_ready == 1'b1, "R7", req_ready, 64'd1);
        done = 1;
      end else if (mode == 1 && cyc == 3) begin
        req_addr  = exp_base | ($urandom % 64);
        req_valid = 1'b1;
        #1 chk(req_ready == 1'b1, "R10", req_ready, 64'd1);
      end else if (mode == 2 && cyc == 2) begin
        req_addr  = a ^ 32'h0000_1000;
        req_valid = 1'b1;
        #1 chk(req_ready == 1'b0, "R9", req_ready, 64'd0);
      end else if ((mode == 1 && cyc == 4) || (mode == 2 && cyc == 5)) begin
        req_valid = 1'b0;
      end
      if (cyc > 500) begin
        chk(0, "R7 watchdog", cyc, 0);
        done = 1;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(fill_done == 1'b0, "R7", fill_done, 64'd0);
    chk(nreq == 8, (mode == 1) ? "R10" : (mode == 2) ? "R9" : "R3", nreq, 64'd8);
    chk(line_addr == exp_base, (mode == 2) ? "R9" : "R1", line_addr, exp_base);
    for (int b = 0; b < 8; b++) begin
      rd_idx = 3'(b);
      @(negedge clk);
      chk(rd_data == mem_word(exp_base + AW'(b * 8)), "R11 R5", rd_data,
          mem_word(exp_base + AW'(b * 8)));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R12", {req_ready, mem_req_valid}, 64'h2);
    chk(beat_valid == 8'd0 && !crit_ready && !fill_done, "R12", beat_valid, 64'd0);
    rst = 1'b0;
    do_fill(32'h0000_1000, 0);
    do_fill(32'h0000_20BF, 0);
    do_fill(32'h0003_0079, 1);
    do_fill(32'h0004_0004, 2);
    for (int i = 0; i < 24; i++) do_fill($urandom, i % 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule